// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It sends an N-bit trial code to an external DAC and reads back one comparator bit. That bit reports whether the analog input lies above the DAC level. Bits are resolved one per clock, starting at the most significant bit. When the least significant bit is settled, the block presents the final code and raises a one-cycle completion strobe.

The bit under trial is selected by a one-hot ring pointer, not by a binary index. The pointer starts at the MSB position and moves one place toward the LSB on each trial clock. The same one-hot vector both marks the bit being decided and places the next trial bit, so no decoder sits in the update path. The pointer is also brought out as a port, which lets the analog side see which bit is being weighed.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start, `busy_o`, `done_o`, `dac_code_o`, `trial_sel_o` and `result_o` are all zero.
- R2: A start sampled high while idle clears the approximation register and sets only its MSB. On the next cycle `dac_code_o` is 1 followed by N-1 zeros, `trial_sel_o` holds a single 1 at bit N-1, and `busy_o` is high.
- R3: If `cmp_i` is high at the clock edge that ends a trial cycle, the bit marked by `trial_sel_o` in that cycle stays 1 in `dac_code_o`.
- R4: If `cmp_i` is low at the clock edge that ends a trial cycle, the bit marked by `trial_sel_o` in that cycle becomes 0 in `dac_code_o`.
- R5: After each non-final trial, `trial_sel_o` moves one position toward bit 0 and that new bit is set in `dac_code_o`. While busy, `trial_sel_o` has exactly one bit set.
- R6: A conversion takes exactly N trial cycles. `done_o` is high for exactly one cycle, which is the cycle after the trial at bit 0, and `busy_o` is low in that cycle.
- R7: In the `done_o` cycle, `result_o` equals the decided code. With a comparator that is high when the DAC code is at most the input level V (0 to 2^N-1), `result_o` equals V.
- R8: `result_o` changes only in a `done_o` cycle and holds its value at all other times, including during a later conversion.
- R9: A start pulse while `busy_o` is high is ignored: the trial sequence, the comparator decisions and the `done_o` timing are unchanged.
- R10: A start sampled in the `done_o` cycle begins a new conversion, because the block is idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled at the clock edge |
| cmp_i | input | 1 | Comparator: 1 when the DAC level is at or below the input |
| dac_code_o | output | N | Trial code to the DAC |
| trial_sel_o | output | N | One-hot pointer to the bit under trial (zero when idle) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe after the final decision |
| result_o | output | N | Final code of the last completed conversion |

## Verification
The bench runs every input level from 0 to 2^N-1 against an ideal threshold comparator. For each level it checks the trial code and the pointer cycle by cycle, so a design that set the next bit before deciding the current one, or applied a decision to the wrong bit, gives the wrong code in a specific cycle. The endpoint levels 0 and all-ones separate an inverted keep/clear rule from a correct one. The done timing exposes a pointer that stops one bit early or runs one bit late. Extra start pulses during a conversion would show up in a design that restarts: the MSB would reappear or done would be delayed. A start in the done cycle, and a reset in the middle of a conversion, cover the boundaries on both sides of the idle state.

// File: rtl/sar_conv_pkg.sv
`timescale 1ns/1ps
package sar_conv_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRIAL = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_ring_ptr.sv
`timescale 1ns/1ps
module sar_ring_ptr #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [N-1:0] sel_o,
  output logic         at_lsb_o
);
  localparam logic [N-1:0] MsbHot = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] ring_q;

  // walks MSB -> LSB, then empties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ring_q <= '0;
    else if (load_i) ring_q <= MsbHot;
    else if (step_i) ring_q <= ring_q >> 1;
  end

  assign sel_o    = ring_q;
  assign at_lsb_o = ring_q[0];
endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
module sar_approx_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         last_i,
  input  logic [N-1:0] sel_i,
  input  logic         cmp_i,
  output logic [N-1:0] code_o,
  output logic [N-1:0] result_o
);
  localparam logic [N-1:0] MsbHot = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] code_q, res_q;
  logic [N-1:0] decided, stepped;

  // settle the bit under trial, then raise the next lower one
  always_comb begin
    decided = (code_q & ~sel_i) | (cmp_i ? sel_i : '0);
    stepped = decided | (sel_i >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= MsbHot;
    else if (step_i) code_q <= stepped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                res_q <= '0;
    else if (step_i && last_i)  res_q <= decided;
  end

  assign code_o   = code_q;
  assign result_o = res_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_conv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic at_lsb_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  sar_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    load_o  = (state_q == ST_IDLE) && start_i;
    step_o  = (state_q == ST_TRIAL);
    last_o  = step_o && at_lsb_i;
    state_d = state_q;
    if (load_o)      state_d = ST_TRIAL;
    else if (last_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_o;
    end
  end

  assign busy_o = (state_q == ST_TRIAL);
  assign done_o = done_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_code_o,
  output logic [N-1:0] trial_sel_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o
);
  logic         load, step, last, at_lsb;
  logic [N-1:0] sel;

  sar_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .at_lsb_i (at_lsb),
    .load_o   (load),
    .step_o   (step),
    .last_o   (last),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  sar_ring_ptr #(.N(N)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .sel_o    (sel),
    .at_lsb_o (at_lsb)
  );

  sar_approx_reg #(.N(N)) u_areg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .last_i   (last),
    .sel_i    (sel),
    .cmp_i    (cmp_i),
    .code_o   (dac_code_o),
    .result_o (result_o)
  );

  assign trial_sel_o = sel;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
module sar_conv_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         cmp_i,
  input logic [N-1:0] dac_code_o,
  input logic [N-1:0] trial_sel_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [N-1:0] result_o
);
  localparam logic [N-1:0] MsbHot = {1'b1, {(N-1){1'b0}}};

  a_r2_start_loads_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && trial_sel_o == MsbHot && dac_code_o == MsbHot));

  a_r5_single_pointer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(trial_sel_o) == 1));

  a_r5_pointer_walks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !trial_sel_o[0]) |=> (trial_sel_o == ($past(trial_sel_o) >> 1)));

  a_r3_keep_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_i) |=> ((dac_code_o & $past(trial_sel_o)) == $past(trial_sel_o)));

  a_r4_clear_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmp_i) |=> ((dac_code_o & $past(trial_sel_o)) == '0));

  a_r6_done_after_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trial_sel_o[0]) |=> (done_o && !busy_o));

  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_result_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == dac_code_o));

  a_r8_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !trial_sel_o[0]) |=> busy_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmp_i       (cmp_i),
  .dac_code_o  (dac_code_o),
  .trial_sel_o (trial_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
  localparam int N = 8;
  localparam int LEVELS = 1 << N;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic         cmp;
  logic [N-1:0] dac_code, trial_sel, result;
  logic         busy, done;
  int           vin = 0;
  int           n_chk = 0;
  int           n_err = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  // ideal threshold: high when DAC level is at or below the input
  assign cmp = (int'(dac_code) <= vin);

  sar_conv_ctrl #(.N(N)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmp_i       (cmp),
    .dac_code_o  (dac_code),
    .trial_sel_o (trial_sel),
    .busy_o      (busy),
    .done_o      (done),
    .result_o    (result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (vin=%0d t=%0t)", tag, act, exp, vin, $time);
    end
  endtask

  // one conversion; start is raised at a negedge, sampling happens at negedges
  task automatic convert(input int level, input bit poke_start, input int prev_res);
    vin = level;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < N; i++) begin
      int b = N - 1 - i;
      int hi_mask = ~((1 << (b + 1)) - 1) & (LEVELS - 1);
      int exp_code = (level & hi_mask) | (1 << b);
      chk(busy == 1'b1 && done == 1'b0, "R6 busy during trial", {busy, done}, 2);
      chk(trial_sel == N'(1 << b), "R5 pointer position", trial_sel, 1 << b);
      chk(dac_code == N'(exp_code), i == 0 ? "R2 first trial code" : "R5 trial code", dac_code, exp_code);
      if (i > 0) begin
        if ((level >> (b + 1)) & 1)
          chk(dac_code[b+1] == 1'b1, "R3 kept bit", dac_code[b+1], 1);
        else
          chk(dac_code[b+1] == 1'b0, "R4 cleared bit", dac_code[b+1], 0);
      end
      chk(result == N'(prev_res), "R8 result holds", result, prev_res);
      if (poke_start && (i == 2 || i == N - 2)) start = 1'b1; // R9
      @(negedge clk) start = 1'b0;
    end
    chk(done == 1'b1 && busy == 1'b0, "R6 done strobe", {busy, done}, 1);
    chk(result == N'(level), "R7 final result", result, level);
  endtask

  initial begin
    int prev;
    #1;
    chk(busy == 0 && done == 0 && dac_code == 0 && trial_sel == 0 && result == 0,
        "R1 in reset", {busy, done, dac_code, result}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && dac_code == 0 && trial_sel == 0 && result == 0,
        "R1 after reset", {busy, done, dac_code, result}, 0);

    // exhaustive sweep of input levels
    prev = 0;
    for (int v = 0; v < LEVELS; v++) begin
      convert(v, 1'b0, prev);
      prev = v;
      @(negedge clk);
      chk(done == 1'b0 && result == N'(v), "R8 after done", {done, result}, v);
    end

    // start pulses during conversion are ignored
    convert(8'hA5, 1'b1, prev); prev = 8'hA5;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 no restart", {busy, done}, 0);
    convert(8'h3C, 1'b1, prev); prev = 8'h3C;

    // start presented in the done cycle is accepted
    start = 1'b1;
    vin = 8'h81;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1 && dac_code == N'(1 << (N - 1)) && trial_sel == N'(1 << (N - 1)),
        "R10 start in done cycle", dac_code, 1 << (N - 1));
    repeat (N) @(negedge clk);
    chk(done == 1'b1 && result == N'(8'h81), "R10 back-to-back result", result, 8'h81);

    // reset in the middle of a conversion
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && dac_code == 0 && trial_sel == 0 && result == 0,
        "R1 mid-conversion reset", {busy, dac_code, result}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    convert(LEVELS - 1, 1'b0, 0);
    convert(0, 1'b0, LEVELS - 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule